// File: doc/BRIEF.md
# Digital Silence Detector with Noise Test Output

This block watches a stereo audio stream that arrives one left/right sample pair per frame strobe. It counts how many frames in a row have carried exactly zero on both channels. Once that run reaches a set length, it raises a flag output that an outside circuit can use to mute an amplifier during digital silence. A single nonzero sample on either channel clears the run, and the flag drops.

The same output pin can also carry a test signal. A one-byte test register sits at control address 511 and is written through a simple write port. While that register holds the value 7, the pin shows the output bit of an internal pseudo-random bit generator instead of the silence flag. The generator steps on a separate enable that runs at 128 times the sample rate. Its sequence is maximal length for 24 bits, so it repeats once every 2^24 - 1 steps.

Top module: `silence_flag`

## Requirements
- R1: After reset the flag output is 0, the run counter is 0, the test register holds 0 and the noise register holds its seed 24'h000001.
- R2: A frame is a cycle with `frame_vld_i` high. The flag output goes to 1 one clock after the 1024th consecutive frame in which both `smp_left_i` and `smp_right_i` are zero. It stays 0 after 1023 such frames.
- R3: A frame with any nonzero bit on either channel resets the run to zero. The flag is 0 one clock after that frame.
- R4: The run count saturates at 1024. The flag stays 1 through any number of further all-zero frames.
- R5: Cycles with `frame_vld_i` low leave the run count and the flag unchanged, whatever the sample inputs carry.
- R6: A write with `cfg_we_i` high and `cfg_addr_i` equal to 511 loads `cfg_wdata_i` into the test register one clock later. Writes to any other address leave the test register unchanged.
- R7: While the test register holds 7, the flag output equals bit 0 of the noise register. While it holds any other value, the flag output is the silence flag.
- R8: The noise register advances only in cycles where `noise_en_i` is high. Each step sets the next state to {s[22:0], s[23]^s[22]^s[21]^s[16]}, which uses the feedback mask 24'hE10000. In all other cycles it holds its value.
- R9: The noise register is never all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_vld_i | input | 1 | Strobe marking one new sample pair |
| smp_left_i | input | 24 | Left channel sample |
| smp_right_i | input | 24 | Right channel sample |
| noise_en_i | input | 1 | Noise step enable at 128 times the sample rate |
| cfg_we_i | input | 1 | Control write strobe |
| cfg_addr_i | input | 9 | Control write address |
| cfg_wdata_i | input | 8 | Control write data |
| flag_o | output | 1 | Silence flag, or noise bit in test mode |

## Verification
Every result of this block is due exactly one rising edge after the edge that samples its cause. A frame updates the run count, a matching write updates the test register, and an enabled cycle steps the noise register, each one edge later. The flag pin is a pure selection of those registered values, so it adds no extra delay. The bench drives inputs on the falling edge. It updates its own arithmetic model after the rising edge that samples them, and compares the pin one time unit after that edge. As a result, the 1023rd/1024th-frame boundary, the one-edge drop after a nonzero sample, and every test-register code from 0 to 255 are each checked in the cycle where they take effect.

// File: rtl/silence_det_pkg.sv
package silence_det_pkg;

  typedef enum logic [0:0] {
    PIN_FLAG  = 1'b0,
    PIN_NOISE = 1'b1
  } pin_src_e;

endpackage

// File: rtl/sd_rst_sync.sv
module sd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/sd_run_counter.sv
module sd_run_counter #(
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 1024
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_vld_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                silent_o
);

  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pair_zero;
  logic             cnt_en;

  assign pair_zero = (left_i == '0) && (right_i == '0);
  assign cnt_en    = frame_vld_i;

  always_comb begin
    cnt_d = cnt_q;
    if (!pair_zero)          cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign silent_o = (cnt_q == CNT_MAX);

  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);

  assert_clear_on_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_i && !pair_zero) |=> (cnt_q == '0) && !silent_o);

  assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_vld_i |=> $stable(cnt_q));

  assert_stay_silent_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (silent_o && frame_vld_i && pair_zero) |=> silent_o);

  assert_rise_needs_frame_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(silent_o) |-> $past(frame_vld_i));

endmodule

// File: rtl/sd_noise_lfsr.sv
module sd_noise_lfsr #(
  parameter int              LFSR_W   = 24,
  parameter logic [LFSR_W-1:0] SEED     = 24'h000001,
  parameter logic [LFSR_W-1:0] TAP_MASK = 24'hE10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic bit_o
);

  logic [LFSR_W-1:0] sr_q, sr_d;
  logic              fb;

  assign fb = ^(sr_q & TAP_MASK);

  always_comb begin
    sr_d = {sr_q[LFSR_W-2:0], fb};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= SEED;
    else if (step_i) sr_q <= sr_d;
  end

  assign bit_o = sr_q[0];

  assert_never_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_q != '0);

  assert_hold_when_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(sr_q));

  assert_shift_when_on_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> sr_q[LFSR_W-1:1] == $past(sr_q[LFSR_W-2:0]));

endmodule

// File: rtl/sd_test_reg.sv
module sd_test_reg
  import silence_det_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int REG_ADDR   = 511,
  parameter int NOISE_CODE = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output pin_src_e          src_o
);

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);
  localparam logic [DATA_W-1:0] CODE     = DATA_W'(NOISE_CODE);

  logic [DATA_W-1:0] reg_q, reg_d;
  logic              hit;

  assign hit = we_i && (addr_i == HIT_ADDR);

  always_comb begin
    reg_d = reg_q;
    if (hit) reg_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reg_q <= '0;
    else         reg_q <= reg_d;
  end

  assign src_o = (reg_q == CODE) ? PIN_NOISE : PIN_FLAG;

  assert_miss_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(reg_q));

  assert_hit_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> reg_q == $past(wdata_i));

  assert_code_select_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && (wdata_i != CODE)) |=> src_o == PIN_FLAG);

endmodule

// File: rtl/silence_flag.sv
module silence_flag
  import silence_det_pkg::*;
#(
  parameter int SAMPLE_W   = 24,
  parameter int RUN_LEN    = 1024,
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int TEST_ADDR  = 511,
  parameter int NOISE_CODE = 7,
  parameter int LFSR_W     = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_vld_i,
  input  logic [SAMPLE_W-1:0] smp_left_i,
  input  logic [SAMPLE_W-1:0] smp_right_i,
  input  logic                noise_en_i,
  input  logic                cfg_we_i,
  input  logic [ADDR_W-1:0]   cfg_addr_i,
  input  logic [DATA_W-1:0]   cfg_wdata_i,
  output logic                flag_o
);

  logic     rst_n_sync;
  logic     silent;
  logic     noise_bit;
  pin_src_e pin_src;

  sd_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  sd_run_counter #(
    .SAMPLE_W (SAMPLE_W),
    .RUN_LEN  (RUN_LEN)
  ) u_run (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_sync),
    .frame_vld_i (frame_vld_i),
    .left_i      (smp_left_i),
    .right_i     (smp_right_i),
    .silent_o    (silent)
  );

  sd_noise_lfsr #(
    .LFSR_W   (LFSR_W),
    .SEED     (LFSR_W'(1)),
    .TAP_MASK (LFSR_W'(24'hE10000))
  ) u_noise (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .step_i (noise_en_i),
    .bit_o  (noise_bit)
  );

  sd_test_reg #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .REG_ADDR   (TEST_ADDR),
    .NOISE_CODE (NOISE_CODE)
  ) u_treg (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_sync),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .src_o   (pin_src)
  );

  always_comb begin
    unique case (pin_src)
      PIN_NOISE: flag_o = noise_bit;
      default:   flag_o = silent;
    endcase
  end

  assert_reset_low_R1: assert property (@(posedge clk_i)
    !rst_n_sync |-> !flag_o);

endmodule

// File: tb/silence_flag_tb.sv
module silence_flag_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SW   = 24;
  localparam int RUN  = 1024;
  localparam int TADR = 511;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          vld;
  logic [SW-1:0] sl, sr;
  logic          nen;
  logic          we;
  logic [8:0]    addr;
  logic [7:0]    wdat;
  logic          flag;

  int total = 0;
  int bad   = 0;

  int          m_cnt;
  logic [7:0]  m_reg;
  logic [23:0] m_lf;

  always #(CLK_PERIOD/2) clk = ~clk;

  silence_flag u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .frame_vld_i (vld),
    .smp_left_i  (sl),
    .smp_right_i (sr),
    .noise_en_i  (nen),
    .cfg_we_i    (we),
    .cfg_addr_i  (addr),
    .cfg_wdata_i (wdat),
    .flag_o      (flag)
  );

  function automatic logic [23:0] lf_next(input logic [23:0] s);
    return {s[22:0], s[23] ^ s[22] ^ s[21] ^ s[16]};
  endfunction

  function automatic logic expected();
    if (m_reg == 8'd7) return m_lf[0];
    return (m_cnt == RUN);
  endfunction

  task automatic check(input logic exp, input string req);
    total++;
    if (flag !== exp) begin
      bad++;
      $display("FAIL %s: flag_o=%b expected=%b at %0t", req, flag, exp, $time);
    end
  endtask

  task automatic step(input logic v, input logic [SW-1:0] l, input logic [SW-1:0] r,
                      input logic en, input logic w, input logic [8:0] a,
                      input logic [7:0] d, input string req);
    @(negedge clk);
    vld = v; sl = l; sr = r; nen = en; we = w; addr = a; wdat = d;
    @(posedge clk);
    if (v) m_cnt = ((l == '0) && (r == '0)) ? ((m_cnt < RUN) ? m_cnt + 1 : RUN) : 0;
    if (w && a == 9'(TADR)) m_reg = d;
    if (en) m_lf = lf_next(m_lf);
    #1;
    check(expected(), req);
  endtask

  task automatic zeros(input int n, input string req);
    for (int i = 0; i < n; i++) step(1'b1, '0, '0, i[0], 1'b0, '0, '0, req);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; vld = 1'b0; sl = '0; sr = '0; nen = 1'b0;
    we = 1'b0; addr = '0; wdat = '0;
    m_cnt = 0; m_reg = '0; m_lf = 24'h000001;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(1'b0, "R1");

    // R2 with R5: 1023 zero frames interleaved with idle nonzero cycles
    for (int i = 0; i < RUN - 1; i++) begin
      step(1'b1, '0, '0, 1'b1, 1'b0, '0, '0, "R2");
      if (i % 97 == 0)
        step(1'b0, 24'hFFFFFF, 24'h000100, 1'b0, 1'b0, '0, '0, "R5");
    end
    check(1'b0, "R2 after 1023 frames");
    step(1'b1, '0, '0, 1'b0, 1'b0, '0, '0, "R2 frame 1024");
    check(1'b1, "R2 flag after 1024th frame");

    // R4: saturation through a long silence, R5 idle data ignored
    zeros(2000, "R4");
    step(1'b0, 24'h800000, 24'h000001, 1'b1, 1'b0, '0, '0, "R5 idle nonzero");
    check(1'b1, "R5 flag held");

    // R3: each single bit on left, then right, clears the run
    for (int b = 0; b < SW; b++) begin
      step(1'b1, SW'(1) << b, '0, 1'b0, 1'b0, '0, '0, "R3 left");
      check(1'b0, "R3 left drop");
      zeros(2, "R3");
    end
    for (int b = 0; b < SW; b++) begin
      step(1'b1, '0, SW'(1) << b, 1'b1, 1'b0, '0, '0, "R3 right");
      check(1'b0, "R3 right drop");
      step(1'b1, '0, '0, 1'b0, 1'b0, '0, '0, "R3");
    end
    zeros(RUN, "R2 refill");
    check(1'b1, "R2 refilled");

    // R6: code 7 at other addresses is ignored
    step(1'b0, '0, '0, 1'b1, 1'b1, 9'd510, 8'd7, "R6 addr 510");
    step(1'b0, '0, '0, 1'b1, 1'b1, 9'd255, 8'd7, "R6 addr 255");
    step(1'b0, '0, '0, 1'b1, 1'b1, 9'd0,   8'd7, "R6 addr 0");
    check(1'b1, "R6 other addresses ignored");

    // R6/R7: sweep every test register value
    for (int v = 0; v < 256; v++) begin
      step(1'b0, '0, '0, 1'b1, 1'b1, 9'(TADR), 8'(v), "R6 write");
      for (int k = 0; k < 8; k++)
        step(1'b0, '0, '0, 1'b1, 1'b0, '0, '0, (v == 7) ? "R7 noise" : "R7 flag");
    end

    // R8/R9: noise stream with enable pattern, and hold while disabled
    step(1'b0, '0, '0, 1'b0, 1'b1, 9'(TADR), 8'd7, "R6 select noise");
    for (int k = 0; k < 600; k++)
      step(1'b0, '0, '0, (k % 3 == 0), 1'b0, '0, '0, "R8 stream");
    for (int k = 0; k < 40; k++)
      step(1'b0, '0, '0, 1'b0, 1'b0, '0, '0, "R8 hold");

    // R7: noise mode leaves silence counting intact
    step(1'b1, 24'h000010, '0, 1'b1, 1'b0, '0, '0, "R3 in noise mode");
    step(1'b0, '0, '0, 1'b1, 1'b1, 9'(TADR), 8'd6, "R7 back to flag");
    check(1'b0, "R7 flag low after clear");

    finish_run();
  end

endmodule